// File: doc/BRIEF.md
# E3 G.751 Receive Frame Aligner

The aligner takes a serial E3 line stream, one bit for each cycle in which `bit_en_i` is high, and locks onto the 1536-bit frame. A frame opens with a 10-bit alignment word. Two single overhead bits follow it: alarm (A) and national (N). The last four bits of the frame carry an optional interleaved parity field. While out of frame, the block slides bit by bit to find the alignment word. A match is confirmed one frame later before the block declares in-frame. Once aligned, it checks the word again in every frame and falls back to search after a run of errored words.

While aligned, the block reports the position of every incoming bit. It raises a payload strobe on non-overhead bits and produces a one-cycle strobe that carries each frame's A and N bits. When parity checking is enabled, it flags a frame whose received parity field does not match the parity computed over the frame before it. Line decoding, clock recovery, loss-of-signal detection and register access lie outside the block.

Top module: `e3_frame_aligner`

## Requirements
- R1: While `rst_ni` is low, and until the first bit after release, `in_frame_o`, `payload_valid_o`, `an_valid_o` and `bip_err_o` are 0 and `bit_pos_o` is 1.
- R2: Out of frame, the word 1111010000 is searched at every bit offset. The leftmost digit is the earliest bit received, and the word sits at frame positions 1 to 10. A first match only starts verification. `in_frame_o` rises one cycle after the enable that carries position 10 of the next frame, and only if the word is found there again, exactly FRAME_LEN bits after the first match.
- R3: If the word is absent at the verification point, the block returns to search and does not declare in-frame.
- R4: In frame, up to LOSS_LIMIT-1 consecutive frames with an errored word keep `in_frame_o` high, and a correct word clears the run. The LOSS_LIMIT-th consecutive errored word (4 by default) drops `in_frame_o` one cycle after the enable carrying position 10 of that frame.
- R5: Cycles with `bit_en_i` low take no bit and leave `bit_pos_o` and the alignment state unchanged.
- R6: For every frame whose position 11 and 12 bits arrive in frame, `an_valid_o` pulses for one cycle, one cycle after the enable carrying position 12. At that point `a_bit_o` holds the position 11 bit and `n_bit_o` holds the position 12 bit. No pulse occurs out of frame.
- R7: `bit_pos_o` is the 1-based frame position of the bit on `bit_i`. `payload_valid_o` is high with `bit_en_i` in frame at positions 13 to FRAME_LEN-4, and up to FRAME_LEN when `bip_en_i` is 0.
- R8: Parity lane k (0 to 3) is the XOR of the bits at positions p in 1..FRAME_LEN-4 of a frame with (p-1) mod 4 = k. The received lane k sits at position FRAME_LEN-3+k of the following frame. A difference on any lane pulses `bip_err_o` for one cycle, one cycle after the enable carrying position FRAME_LEN. The check applies only if that previous frame was in frame from its position 1 onward.
- R9: With `bip_en_i` low at the last bit of a frame, `bip_err_o` stays 0 for that frame whatever the parity field holds.
- R10: Asserting `rst_ni` mid-stream drops `in_frame_o` at once, returns `bit_pos_o` to 1, and restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial line bit |
| bip_en_i | input | 1 | Enables parity-field checking; when low the field counts as payload |
| in_frame_o | output | 1 | Frame alignment held |
| bit_pos_o | output | POS_W (11) | 1-based frame position of `bit_i` |
| payload_valid_o | output | 1 | `bit_i` is a payload bit |
| an_valid_o | output | 1 | One-cycle strobe: `a_bit_o`/`n_bit_o` updated |
| a_bit_o | output | 1 | Alarm bit of the latest frame |
| n_bit_o | output | 1 | National bit of the latest frame |
| bip_err_o | output | 1 | One-cycle parity mismatch pulse |

## Verification
The bench builds the aligner with FRAME_LEN = 64 and keeps the default word, LOSS_LIMIT of 4 and 4 parity lanes. This leaves the overhead layout and the parity region exactly as at full length, while a frame costs only about 70 cycles. That is short enough to walk twenty frames through acquisition, a failed verification and a loss after four errored words. It also reaches reacquisition, a parity check withheld for the first full frame and a corrupt field with checking disabled. Idle cycles inserted into odd frames confirm that positions only advance on enabled bits.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } fa_state_e;
endpackage

// File: rtl/e3fa_word_detect.sv
module e3fa_word_detect #(
  parameter int                  WORD_LEN = 10,
  parameter logic [WORD_LEN-1:0] WORD     = 10'b1111010000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic match_o
);
  logic [WORD_LEN-1:0] sr_q, sr_next;

  // earliest bit ends up in the MSB
  assign sr_next = {sr_q[WORD_LEN-2:0], bit_i};
  assign match_o = bit_en_i && (sr_next == WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (bit_en_i) sr_q <= sr_next;
  end

  p_hold_no_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(sr_q));
endmodule

// File: rtl/e3fa_bit_counter.sv
module e3fa_bit_counter #(
  parameter int FRAME_LEN = 1536,
  parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_o <= POS_FIRST;
    else if (load_i) pos_o <= load_val_i;
    else if (step_i) pos_o <= (pos_o == POS_LAST) ? POS_FIRST : pos_o + POS_FIRST;
  end

  p_pos_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o >= POS_FIRST && pos_o <= POS_LAST);
  p_pos_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(pos_o));
endmodule

// File: rtl/e3fa_sync_fsm.sv
module e3fa_sync_fsm
  import e3fa_pkg::*;
#(
  parameter int LOSS_LIMIT = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      match_i,
  input  logic      check_i,
  output fa_state_e state_o,
  output logic      load_o
);
  localparam int             CNT_W     = $clog2(LOSS_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LOSS_LIMIT);

  fa_state_e        state_d;
  logic [CNT_W-1:0] miss_q, miss_d;
  logic             at_check;

  assign at_check = bit_en_i && check_i;
  assign load_o   = (state_o == ST_SEARCH) && match_i;

  always_comb begin
    state_d = state_o;
    miss_d  = miss_q;
    unique case (state_o)
      ST_SEARCH: begin
        miss_d = '0;
        if (match_i) state_d = ST_VERIFY;
      end
      ST_VERIFY: if (at_check) state_d = match_i ? ST_SYNC : ST_SEARCH;
      ST_SYNC: begin
        if (at_check) begin
          if (match_i) miss_d = '0;
          else if (miss_q + CNT_ONE == CNT_LIM) begin
            miss_d  = '0;
            state_d = ST_SEARCH;
          end else miss_d = miss_q + CNT_ONE;
        end
      end
      default: state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_SEARCH;
      miss_q  <= '0;
    end else begin
      state_o <= state_d;
      miss_q  <= miss_d;
    end
  end

  p_sync_via_verify_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o == ST_SYNC) |-> $past(state_o) == ST_VERIFY);
  p_verify_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_VERIFY && state_o != ST_VERIFY) |-> $past(at_check));
  p_miss_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q < CNT_LIM);
  p_loss_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_SYNC && state_o == ST_SEARCH) |-> $past(miss_q) == CNT_LIM - CNT_ONE);
  p_state_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(state_o));
endmodule

// File: rtl/e3fa_bip_check.sv
module e3fa_bip_check #(
  parameter int FRAME_LEN = 1536,
  parameter int BIP_W     = 4,
  parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             in_sync_i,
  input  logic             bip_en_i,
  output logic             bip_err_o
);
  // BIP_W must be a power of two dividing FRAME_LEN
  localparam int               LANE_W       = (BIP_W > 1) ? $clog2(BIP_W) : 1;
  localparam logic [POS_W-1:0] POS_FIRST    = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST     = POS_W'(FRAME_LEN);
  localparam logic [POS_W-1:0] POS_DATA_END = POS_W'(FRAME_LEN - BIP_W);

  logic [LANE_W-1:0] lane;
  logic [BIP_W-1:0]  lane_hit, lane_bits;
  logic [BIP_W-1:0]  acc_q, ref_q;
  logic              acc_full_q, ref_ok_q, err_q;
  logic              in_data, bit_bad;

  assign lane = LANE_W'(pos_i - POS_FIRST);

  for (genvar k = 0; k < BIP_W; k++) begin : g_lane
    assign lane_hit[k] = (lane == LANE_W'(k));
  end

  assign lane_bits = bit_i ? lane_hit : '0;
  assign in_data   = pos_i <= POS_DATA_END;
  assign bit_bad   = bit_i ^ ref_q[lane];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      ref_q      <= '0;
      acc_full_q <= 1'b0;
      ref_ok_q   <= 1'b0;
      err_q      <= 1'b0;
      bip_err_o  <= 1'b0;
    end else begin
      bip_err_o <= 1'b0;
      if (!in_sync_i) begin
        acc_full_q <= 1'b0;
        ref_ok_q   <= 1'b0;
        err_q      <= 1'b0;
      end else if (bit_en_i) begin
        if (pos_i == POS_FIRST) begin
          acc_q      <= lane_bits;
          acc_full_q <= 1'b1;
        end else if (in_data) begin
          acc_q <= acc_q ^ lane_bits;
        end
        if (!in_data) begin
          if (pos_i == POS_LAST) begin
            bip_err_o <= bip_en_i && ref_ok_q && (err_q || bit_bad);
            err_q     <= 1'b0;
            ref_q     <= acc_q;
            ref_ok_q  <= acc_full_q;
          end else begin
            err_q <= err_q || bit_bad;
          end
        end
      end
    end
  end

  p_bip_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_err_o |=> !bip_err_o);
  p_bip_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_err_o |-> $past(pos_i) == POS_LAST && $past(in_sync_i));
  p_bip_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_err_o |-> $past(bip_en_i));
endmodule

// File: rtl/e3_frame_aligner.sv
module e3_frame_aligner
  import e3fa_pkg::*;
#(
  parameter int                  FRAME_LEN  = 1536,
  parameter int                  WORD_LEN   = 10,
  parameter logic [WORD_LEN-1:0] WORD       = 10'b1111010000,
  parameter int                  LOSS_LIMIT = 4,
  parameter int                  BIP_W      = 4,
  localparam int                 POS_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             bip_en_i,
  output logic             in_frame_o,
  output logic [POS_W-1:0] bit_pos_o,
  output logic             payload_valid_o,
  output logic             an_valid_o,
  output logic             a_bit_o,
  output logic             n_bit_o,
  output logic             bip_err_o
);
  localparam logic [POS_W-1:0] POS_CHECK    = POS_W'(WORD_LEN);
  localparam logic [POS_W-1:0] POS_A        = POS_W'(WORD_LEN + 1);
  localparam logic [POS_W-1:0] POS_N        = POS_W'(WORD_LEN + 2);
  localparam logic [POS_W-1:0] POS_PAY      = POS_W'(WORD_LEN + 3);
  localparam logic [POS_W-1:0] POS_DATA_END = POS_W'(FRAME_LEN - BIP_W);

  fa_state_e state;
  logic      match, load, in_sync;

  e3fa_word_detect #(.WORD_LEN(WORD_LEN), .WORD(WORD)) u_detect (
    .clk_i, .rst_ni, .bit_en_i, .bit_i, .match_o(match)
  );

  e3fa_bit_counter #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_count (
    .clk_i, .rst_ni, .step_i(bit_en_i), .load_i(load),
    .load_val_i(POS_A), .pos_o(bit_pos_o)
  );

  e3fa_sync_fsm #(.LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
    .clk_i, .rst_ni, .bit_en_i, .match_i(match),
    .check_i(bit_pos_o == POS_CHECK), .state_o(state), .load_o(load)
  );

  e3fa_bip_check #(.FRAME_LEN(FRAME_LEN), .BIP_W(BIP_W), .POS_W(POS_W)) u_bip (
    .clk_i, .rst_ni, .bit_en_i, .bit_i, .pos_i(bit_pos_o),
    .in_sync_i(in_sync), .bip_en_i, .bip_err_o
  );

  assign in_sync    = (state == ST_SYNC);
  assign in_frame_o = in_sync;

  assign payload_valid_o = bit_en_i && in_sync && (bit_pos_o >= POS_PAY) &&
                           (!bip_en_i || bit_pos_o <= POS_DATA_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      an_valid_o <= 1'b0;
      a_bit_o    <= 1'b0;
      n_bit_o    <= 1'b0;
    end else begin
      an_valid_o <= 1'b0;
      if (bit_en_i && in_sync) begin
        if (bit_pos_o == POS_A) a_bit_o <= bit_i;
        if (bit_pos_o == POS_N) begin
          n_bit_o    <= bit_i;
          an_valid_o <= 1'b1;
        end
      end
    end
  end

  p_an_in_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_valid_o |-> $past(in_frame_o) && $past(bit_pos_o) == POS_N);
  p_an_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_valid_o |=> !an_valid_o);
  p_drop_at_check_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_frame_o) |-> $past(bit_pos_o) == POS_CHECK);
  p_rise_at_check_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_o) |-> $past(bit_pos_o) == POS_CHECK && bit_pos_o == POS_A);
endmodule

// File: tb/e3_frame_aligner_bench.sv
module e3_frame_aligner_bench;
  localparam int L  = 64;
  localparam int PW = $clog2(L + 1);
  localparam logic [9:0] AW = 10'b1111010000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni, bit_en_i, bit_i, bip_en_i;
  logic          in_frame_o, payload_valid_o, an_valid_o, a_bit_o, n_bit_o, bip_err_o;
  logic [PW-1:0] bit_pos_o;

  e3_frame_aligner #(.FRAME_LEN(L)) u_e3_frame_aligner (
    .clk_i(clk), .rst_ni, .bit_en_i, .bit_i, .bip_en_i, .in_frame_o, .bit_pos_o,
    .payload_valid_o, .an_valid_o, .a_bit_o, .n_bit_o, .bip_err_o
  );

  // {a, n, word_bad, bip_bad, bip_en, exp_in, exp_an, exp_bip, exp_payload[7:0]}
  localparam logic [15:0] TBL [20] = '{
    16'h8800, 16'h4E30, 16'hDE30, 16'h0E30, 16'h9F30,
    16'h5634, 16'hEE30, 16'h2E30, 16'hAE30, 16'h4E30,
    16'hEE30, 16'h2E30, 16'hAE30, 16'h6800, 16'hC800,
    16'h2800, 16'h8800, 16'h4E30, 16'hDE30, 16'h1F30
  };

  int checks = 0, fails = 0;
  int an_cnt, bip_cnt, pay_cnt;
  logic an_a, an_n;
  logic [3:0] par_cur, par_prev;

  always @(negedge clk) begin
    if (an_valid_o) begin an_cnt++; an_a = a_bit_o; an_n = n_bit_o; end
    if (bip_err_o) bip_cnt++;
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic put_bit(logic b, logic en);
    @(negedge clk);
    bit_en_i = en;
    bit_i    = b;
    #2;
    if (en && payload_valid_o) pay_cnt++;
  endtask

  task automatic send_frame(int f, logic [15:0] row);
    for (int p = 1; p <= L; p++) begin
      logic b;
      if (p <= 10)      b = AW[10-p] ^ (row[13] && p == 1);
      else if (p == 11) b = row[15];
      else if (p == 12) b = row[14];
      else if (p > L-4) b = par_prev[(p-1)%4] ^ (row[12] && p == L-3);
      else              b = (p == 16 + f % 8);
      if (p <= L-4) begin
        if (p == 1) par_cur = '0;
        par_cur[(p-1)%4] = par_cur[(p-1)%4] ^ b;
      end
      if (f % 2 == 1 && p % 7 == 0) begin
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b0);
        check_eq("R5 position held over idle cycles", int'(bit_pos_o), p);
      end
      put_bit(b, 1'b1);
      if (p == L && f >= 1) check_eq("R7 bit position", int'(bit_pos_o), L);
    end
    par_prev = par_cur;
    put_bit(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; bit_en_i = 1'b0; bit_i = 1'b0; bip_en_i = 1'b1;
    par_prev = '0; par_cur = '0;
    an_cnt = 0; bip_cnt = 0; pay_cnt = 0; an_a = 0; an_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check_eq("R1 in_frame at reset", in_frame_o, 0);
    check_eq("R1 bit_pos at reset", int'(bit_pos_o), 1);
    check_eq("R1 an strobe at reset", an_valid_o, 0);
    check_eq("R1 bip pulse at reset", bip_err_o, 0);
    check_eq("R1 payload at reset", payload_valid_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b1);

    for (int f = 0; f < 20; f++) begin
      logic [15:0] row;
      string lbl;
      row = TBL[f];
      lbl = (f == 15) ? "R3" : (f >= 6 && f <= 13) ? "R4" : "R2";
      bip_en_i = row[11];
      an_cnt = 0; bip_cnt = 0; pay_cnt = 0;
      send_frame(f, row);
      check_eq($sformatf("%s in_frame frame %0d", lbl, f), in_frame_o, row[10]);
      check_eq($sformatf("R6 strobe count frame %0d", f), an_cnt, row[9]);
      if (row[9]) begin
        check_eq($sformatf("R6 A bit frame %0d", f), an_a, row[15]);
        check_eq($sformatf("R6 N bit frame %0d", f), an_n, row[14]);
      end
      check_eq($sformatf("%s parity pulses frame %0d", (f == 5) ? "R9" : "R8", f),
               bip_cnt, row[8]);
      check_eq($sformatf("R7 payload count frame %0d", f), pay_cnt, int'(row[7:0]));
    end

    @(negedge clk) rst_ni = 1'b0;
    #1;
    check_eq("R10 in_frame after mid-stream reset", in_frame_o, 0);
    check_eq("R10 bit_pos after mid-stream reset", int'(bit_pos_o), 1);
    @(negedge clk) rst_ni = 1'b1;
    send_frame(0, 16'h8800);
    check_eq("R10 single match after reset stays out of frame", in_frame_o, 0);
    send_frame(2, 16'h4E30);
    check_eq("R10 reacquired after reset", in_frame_o, 1);

    summary();
    $finish;
  end
endmodule